// File: doc/BRIEF.md
# Domain-Tagged Permission Lookaside Cache

This block is a small, fully associative cache of memory-protection entries. It does no address translation. Each entry grants one two-bit permission over a naturally aligned, power-of-two address range, and it belongs to one protection domain. A lookup supplies a domain ID, an address and an access kind. In the same cycle the block answers with hit, miss, the stored permission and a fault flag. The lookup path is purely combinational over the stored entries.

When a lookup misses, the miss output serves as the request to an external table walker. The walker sends its result back on the refill port. The refill is written on the next clock edge and is visible to lookups from the following cycle. A refill for a range that is already cached overwrites that entry. Any other refill takes the slot named by a round-robin pointer. A flush port drops every entry of one domain in a single cycle.

Top module: `perm_lookaside`

## Requirements
- R1: After reset no entry is valid, so every lookup misses with hit 0, fault 0 and permission 00.
- R2: A lookup hits when a valid entry has an equal domain and the address agrees with the entry base outside the entry's don't-care low bits. Size code 00 covers 4 bytes, 01 covers 256 bytes, 10 covers 256 KB, and 11 is treated as 4 bytes.
- R3: An entry whose domain differs from the lookup domain never produces a hit.
- R4: `lk_miss` is high exactly when `lk_valid` is high and no entry matches. When `lk_valid` is low, both `lk_hit` and `lk_miss` are low.
- R5: Permission codes are 00 none, 01 read-only, 10 read-write and 11 execute-read. On a hit `lk_perm` carries the entry's code; otherwise it is 00.
- R6: Access codes are 00 read, 01 write and 10 fetch; code 11 is treated as read. A fault is raised only on a hit, in these cases: a read meets 00, a write meets anything but 10, or a fetch meets anything but 11.
- R7: When several entries match, the entry with the lowest index supplies the permission.
- R8: A refill stores its address with the don't-care low bits cleared, so the entry covers the whole aligned range that contains that address.
- R9: A refill that matches no existing entry writes the slot at the round-robin pointer. The pointer starts at 0 after reset and advances by one per such refill, wrapping after the last slot.
- R10: A refill whose domain, size and aligned base equal those of a valid entry overwrites that entry's permission. The pointer does not move.
- R11: A flush invalidates every entry of the given domain and leaves all other entries intact. The effect is visible from the next cycle.
- R12: When a flush and a refill occur in the same cycle, the refill slot is chosen from the state before the flush, and the refilled entry stays valid.
- R13: A refill is visible to lookups in the cycle after the one in which it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_dom | input | DOM_W | Lookup domain ID |
| lk_addr | input | ADDR_W | Lookup address |
| lk_acc | input | 2 | Access kind (00 read, 01 write, 10 fetch) |
| lk_hit | output | 1 | A valid entry matched |
| lk_miss | output | 1 | Lookup found no entry; refill request |
| lk_perm | output | 2 | Permission of the selected entry |
| lk_fault | output | 1 | Access not allowed by the hit permission |
| fill_valid | input | 1 | Refill write strobe |
| fill_dom | input | DOM_W | Refill domain ID |
| fill_addr | input | ADDR_W | Address inside the refilled range |
| fill_size | input | 2 | Range size code |
| fill_perm | input | 2 | Permission for the range |
| flush_valid | input | 1 | Flush strobe |
| flush_dom | input | DOM_W | Domain to flush |

## Verification
The bench builds the block with 4 entries, 2-bit domains and a 20-bit address. At that size a handful of refills is enough to wrap the replacement pointer and evict entries. Every domain, every access code and a fixed list of addresses can be swept after each step. The address list straddles the edges of 4-byte, 256-byte and 256 KB ranges. The sweeps therefore reach range boundaries, overlapping entries of different sizes, cross-domain lookups and all permission and access pairs.

// File: rtl/perm_lookaside.sv
module perm_lookaside #(
  parameter int ENTRIES = 60,
  parameter int DOM_W   = 8,
  parameter int ADDR_W  = 32,
  parameter int SH_WORD = 2,
  parameter int SH_SUB  = 8,
  parameter int SH_BIG  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [DOM_W-1:0]  lk_dom,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic [1:0]        lk_acc,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [1:0]        lk_perm,
  output logic              lk_fault,
  input  logic              fill_valid,
  input  logic [DOM_W-1:0]  fill_dom,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [1:0]        fill_size,
  input  logic [1:0]        fill_perm,
  input  logic              flush_valid,
  input  logic [DOM_W-1:0]  flush_dom
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  function automatic logic [ADDR_W-1:0] span(input logic [1:0] sz);
    int sh;
    logic [ADDR_W-1:0] m;
    case (sz)
      2'b01:   sh = SH_SUB;
      2'b10:   sh = SH_BIG;
      default: sh = SH_WORD;
    endcase
    for (int b = 0; b < ADDR_W; b++) m[b] = (b < sh);
    return m;
  endfunction

  logic              e_vld  [ENTRIES];
  logic [DOM_W-1:0]  e_dom  [ENTRIES];
  logic [ADDR_W-1:0] e_base [ENTRIES];
  logic [ADDR_W-1:0] e_mask [ENTRIES];
  logic [1:0]        e_perm [ENTRIES];

  logic [ENTRIES-1:0] lk_m, fl_m;
  logic [IDX_W-1:0]   lk_sel, fl_sel, rr, tgt;
  logic [ADDR_W-1:0]  f_mask, f_base;
  logic               viol;

  assign f_mask = span(fill_size);
  assign f_base = fill_addr & ~f_mask;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign lk_m[i] = e_vld[i] && (e_dom[i] == lk_dom) &&
                     (((lk_addr ^ e_base[i]) & ~e_mask[i]) == '0);
    assign fl_m[i] = e_vld[i] && (e_dom[i] == fill_dom) &&
                     (e_mask[i] == f_mask) && (e_base[i] == f_base);
  end

  always_comb begin
    lk_sel = '0;
    fl_sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_m[i]) lk_sel = IDX_W'(i);
      if (fl_m[i]) fl_sel = IDX_W'(i);
    end
  end

  assign tgt     = (|fl_m) ? fl_sel : rr;
  assign lk_hit  = lk_valid & (|lk_m);
  assign lk_miss = lk_valid & ~(|lk_m);
  assign lk_perm = lk_hit ? e_perm[lk_sel] : 2'b00;

  always_comb begin
    case (lk_acc)
      2'b01:   viol = (lk_perm != 2'b10);
      2'b10:   viol = (lk_perm != 2'b11);
      default: viol = (lk_perm == 2'b00);
    endcase
  end
  assign lk_fault = lk_hit & viol;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        e_vld[i]  <= 1'b0;
        e_dom[i]  <= '0;
        e_base[i] <= '0;
        e_mask[i] <= '0;
        e_perm[i] <= 2'b00;
      end
    end else begin
      if (flush_valid)
        for (int i = 0; i < ENTRIES; i++)
          if (e_vld[i] && e_dom[i] == flush_dom) e_vld[i] <= 1'b0;
      if (fill_valid) begin
        e_vld[tgt]  <= 1'b1;
        e_dom[tgt]  <= fill_dom;
        e_base[tgt] <= f_base;
        e_mask[tgt] <= f_mask;
        e_perm[tgt] <= fill_perm;
        if (!(|fl_m)) rr <= (rr == LAST) ? '0 : rr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/perm_lookaside_chk.sv
module perm_lookaside_chk #(
  parameter int DOM_W  = 8,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [DOM_W-1:0]  lk_dom,
  input logic [ADDR_W-1:0] lk_addr,
  input logic [1:0]        lk_acc,
  input logic              lk_hit,
  input logic              lk_miss,
  input logic [1:0]        lk_perm,
  input logic              lk_fault,
  input logic              fill_valid,
  input logic [DOM_W-1:0]  fill_dom,
  input logic [ADDR_W-1:0] fill_addr,
  input logic              flush_valid,
  input logic [DOM_W-1:0]  flush_dom
);
  p_fault_needs_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_hit);

  p_hit_miss_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss) && (lk_valid || (!lk_hit && !lk_miss)));

  p_write_rw_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_acc == 2'b01 && lk_perm == 2'b10) |-> !lk_fault);

  p_miss_perm_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_perm == 2'b00));

  p_fill_visible_r13: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> (!(lk_valid && lk_dom == $past(fill_dom) &&
                      lk_addr == $past(fill_addr)) || lk_hit));

  p_flush_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && !(fill_valid && fill_dom == flush_dom)) |=>
      !(lk_hit && lk_dom == $past(flush_dom)));
endmodule

bind perm_lookaside perm_lookaside_chk #(.DOM_W(DOM_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_dom(lk_dom),
  .lk_addr(lk_addr), .lk_acc(lk_acc), .lk_hit(lk_hit), .lk_miss(lk_miss),
  .lk_perm(lk_perm), .lk_fault(lk_fault), .fill_valid(fill_valid),
  .fill_dom(fill_dom), .fill_addr(fill_addr), .flush_valid(flush_valid),
  .flush_dom(flush_dom)
);

// File: tb/perm_lookaside_tb_top.sv
module perm_lookaside_tb_top;
  localparam int N = 4, DW = 2, AW = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, fill_valid = 0, flush_valid = 0;
  logic [DW-1:0] lk_dom = '0, fill_dom = '0, flush_dom = '0;
  logic [AW-1:0] lk_addr = '0, fill_addr = '0;
  logic [1:0] lk_acc = '0, fill_size = '0, fill_perm = '0;
  logic lk_hit, lk_miss, lk_fault;
  logic [1:0] lk_perm;

  always #10 clk = ~clk;

  perm_lookaside #(.ENTRIES(N), .DOM_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_dom(lk_dom),
    .lk_addr(lk_addr), .lk_acc(lk_acc), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_perm(lk_perm), .lk_fault(lk_fault), .fill_valid(fill_valid),
    .fill_dom(fill_dom), .fill_addr(fill_addr), .fill_size(fill_size),
    .fill_perm(fill_perm), .flush_valid(flush_valid), .flush_dom(flush_dom));

  bit            mv  [N];
  logic [DW-1:0] md  [N];
  logic [AW-1:0] mb  [N];
  int            msh [N];
  logic [1:0]    mp  [N];
  int mrr = 0, errs = 0, checks = 0;
  logic [AW-1:0] alist [16] = '{20'h0, 20'h100, 20'h104, 20'h108, 20'h10C,
    20'h1FC, 20'h200, 20'h204, 20'h2FF, 20'h300, 20'h3FFFC, 20'h40000,
    20'h40104, 20'h7FFFC, 20'h80000, 20'hFFFFC};

  function automatic int shf(input logic [1:0] s);
    return (s == 2'b01) ? 8 : (s == 2'b10) ? 18 : 2;
  endfunction

  task automatic op(input bit fe, input logic [DW-1:0] fd, input logic [AW-1:0] fa,
                    input logic [1:0] fs, input logic [1:0] fp,
                    input bit xe, input logic [DW-1:0] xd);
    int found, tg, sh;
    logic [AW-1:0] base;
    @(negedge clk);
    lk_valid = 0;
    fill_valid = fe; fill_dom = fd; fill_addr = fa; fill_size = fs; fill_perm = fp;
    flush_valid = xe; flush_dom = xd;
    @(posedge clk);
    sh = shf(fs);
    base = (fa >> sh) << sh;
    found = -1;
    for (int i = N - 1; i >= 0; i--)
      if (mv[i] && md[i] == fd && msh[i] == sh && mb[i] == base) found = i;
    tg = (found >= 0) ? found : mrr;
    if (xe) for (int i = 0; i < N; i++) if (mv[i] && md[i] == xd) mv[i] = 0;
    if (fe) begin
      mv[tg] = 1; md[tg] = fd; mb[tg] = base; msh[tg] = sh; mp[tg] = fp;
      if (found < 0) mrr = (mrr + 1) % N;
    end
    #1 fill_valid = 0; flush_valid = 0;
  endtask

  task automatic look(input logic [DW-1:0] d, input logic [AW-1:0] a,
                      input logic [1:0] acc, input string tag);
    bit eh, ef;
    logic [1:0] ep;
    int s;
    @(negedge clk);
    lk_valid = 1; lk_dom = d; lk_addr = a; lk_acc = acc;
    #4;
    s = -1;
    for (int i = N - 1; i >= 0; i--)
      if (mv[i] && md[i] == d && ((a ^ mb[i]) >> msh[i]) == 0) s = i;
    eh = (s >= 0);
    ep = eh ? mp[s] : 2'b00;
    ef = eh && ((acc == 2'b01) ? ep != 2'b10 : (acc == 2'b10) ? ep != 2'b11 : ep == 2'b00);
    checks++;
    if (lk_hit !== eh || lk_miss !== !eh || lk_perm !== ep || lk_fault !== ef) begin
      errs++;
      $display("FAIL %s dom=%0d addr=%h acc=%0d: hit/miss/perm/fault=%b%b%0d%b expected %b%b%0d%b",
               tag, d, a, acc, lk_hit, lk_miss, lk_perm, lk_fault, eh, !eh, ep, ef);
    end
  endtask

  task automatic sweep(input string tag);
    for (int d = 0; d < 4; d++)
      for (int k = 0; k < 16; k++)
        for (int c = 0; c < 4; c++)
          look(DW'(d), alist[k], 2'(c), tag);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin mv[i] = 0; md[i] = 0; mb[i] = 0; msh[i] = 2; mp[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    sweep("R1");
    @(negedge clk); lk_valid = 0; #4;
    checks++;
    if (lk_hit !== 0 || lk_miss !== 0) begin
      errs++; $display("FAIL R4 idle: hit/miss=%b%b expected 00", lk_hit, lk_miss);
    end
    op(1, 2'd1, 20'h40123, 2'b10, 2'b10, 0, 0);
    sweep("R2 R3 R8 R13");
    op(1, 2'd2, 20'h2AB, 2'b01, 2'b01, 0, 0);
    op(1, 2'd1, 20'h40104, 2'b00, 2'b01, 0, 0);
    op(1, 2'd0, 20'h104, 2'b11, 2'b00, 0, 0);
    sweep("R5 R6 R7");
    op(1, 2'd1, 20'h7FFF0, 2'b10, 2'b11, 0, 0);
    sweep("R10");
    op(1, 2'd3, 20'h100, 2'b00, 2'b10, 0, 0);
    op(1, 2'd0, 20'h108, 2'b00, 2'b11, 0, 0);
    sweep("R9");
    op(0, 0, 0, 0, 0, 1, 2'd2);
    sweep("R11");
    op(1, 2'd0, 20'h10C, 2'b00, 2'b01, 1, 2'd0);
    sweep("R12");
    op(1, 2'd1, 20'h40104, 2'b00, 2'b10, 1, 2'd1);
    sweep("R12 R11");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule